// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is an I2C target that looks to a bus controller like a small serial EEPROM. Its storage is an internal byte array whose depth is a power-of-two parameter. It watches the synchronised SCL and SDA inputs for START and STOP conditions. It compares each control byte with a fixed tag and with its three strap pins, and it answers on the bus only through an open-drain pull-low enable for SDA.

A write transfer sends two address bytes and then any number of data bytes. The data bytes land at consecutive locations inside one 64-byte page. A read transfer returns data starting at the internal pointer. The pointer is loaded by a preceding address phase, which gives a random read when a repeated START follows. The pointer is kept from the previous access when no address phase comes first, which gives a current-address read. A read carries on byte after byte for as long as the controller acknowledges. A busy flag and the live pointer are brought out for debug.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The block acknowledges a control byte only if bits 7..4 are 1010 and bits 3..1 equal `dev_sel_i`. Bit 0 selects the direction: 1 means read and 0 means write. On a mismatch the block holds SDA released for the rest of the transfer.
- R2: After every byte the block accepts, it holds `sda_pull_o` high for the whole ninth SCL pulse and releases it after that pulse's falling edge.
- R3: After a write control byte, the first byte is the high address byte and the second is the low address byte. Each later byte is stored at the pointer, and the pointer then advances.
- R4: During a write, the pointer advances only within the current 64-byte page: offset 63 is followed by offset 0 of the same page. The 65th data byte of a burst therefore overwrites the first one.
- R5: Read data is driven MSB first, and each bit is set up while SCL is low. Each byte sent advances the pointer, so a current-address read returns the location after the last one accessed.
- R6: A controller ACK on the ninth clock of a read byte starts the next byte. Sequential reads wrap from the last location to location 0.
- R7: If SDA is left high on the ninth clock of a read byte, the block releases SDA and ignores further clocks until a START or STOP.
- R8: A STOP, whenever it occurs, returns the block to idle with SDA released and `busy_o` low. Clocked bytes are then ignored until a START.
- R9: A START at any point, including a repeated START within a transfer, clears the bit count and restarts control-byte reception.
- R10: `sda_pull_o` changes only while SCL is low.
- R11: The two address bytes are taken modulo the memory depth, so address bits above the array size have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| dev_sel_i | input | 3 | Strap pins compared with control-byte bits 3..1 |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| busy_o | output | 1 | Debug: high between a START and the next STOP |
| ptr_o | output | $clog2(DEPTH) | Debug: current internal address pointer |

## Verification
Two things can happen on the same SCL falling edge: the data byte is stored, and the pointer steps, wrapping within the page. Two things can also overlap at the end of an acknowledged byte: a START resets the bit count while the ACK release or the loading of the next read byte is still due. To provoke the first pair, a burst starts 16 bytes before a page end and then a 65-byte burst runs; both are read back, and every returned bit must match a behavioural byte-array model. To provoke the second pair, a repeated START follows immediately after the address phase, and a STOP lands mid-byte. These are judged by comparing the expected SDA pull level at every SCL high phase, together with the busy and pointer outputs.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;

    // Fixed upper nibble of every control byte this target answers
    localparam logic [3:0] CTRL_TAG = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,   // no transfer open
        ST_CTRL,   // receiving control byte
        ST_AHI,    // receiving high address byte
        ST_ALO,    // receiving low address byte
        ST_WDATA,  // receiving data bytes
        ST_RDATA,  // transmitting data bytes
        ST_PARK    // released, waiting for START or STOP
    } ee_state_e;

    // Events decoded from the synchronised bus lines
    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic ctrl_hit(input logic [7:0] b, input logic [2:0] sel);
        return (b[7:4] == CTRL_TAG) && (b[3:1] == sel);
    endfunction

endpackage

// File: rtl/ee_bus_mon.sv
module ee_bus_mon
    import eeprom_slave_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] scl_q, sda_q;
    logic         scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[MSB-1:0], scl_i};
            sda_q <= {sda_q[MSB-1:0], sda_i};
            scl_d <= scl_q[MSB];
            sda_d <= sda_q[MSB];
        end
    end

    always_comb begin
        evt_o.scl   = scl_q[MSB];
        evt_o.sda   = sda_q[MSB];
        evt_o.rise  = scl_q[MSB] & ~scl_d;
        evt_o.fall  = ~scl_q[MSB] & scl_d;
        evt_o.start = scl_q[MSB] & scl_d & sda_d & ~sda_q[MSB];
        evt_o.stop  = scl_q[MSB] & scl_d & ~sda_d & sda_q[MSB];
    end

endmodule

// File: rtl/ee_array.sv
module ee_array #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import eeprom_slave_pkg::*;
#(
    parameter int DEPTH       = 512,
    parameter int PAGE        = 64,
    parameter int SYNC_STAGES = 2,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [2:0]    dev_sel_i,
    output logic          sda_pull_o,
    output logic          busy_o,
    output logic [AW-1:0] ptr_o
);
    localparam logic [AW-1:0] PMASK = AW'(PAGE - 1);

    bus_evt_t      evt;
    ee_state_e     state;
    logic [3:0]    bit_cnt;
    logic [7:0]    shreg, txreg, ahi;
    logic [AW-1:0] ptr, ptr_page_nxt;
    logic [15:0]   word_addr;
    logic [7:0]    rdata;
    logic          pull, mack, we;

    ee_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    assign we = evt.fall && (bit_cnt == 4'd8) && (state == ST_WDATA)
                && !evt.start && !evt.stop;

    ee_array #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (ptr),
        .wdata (shreg),
        .raddr (ptr),
        .rdata (rdata)
    );

    assign ptr_page_nxt = (ptr & ~PMASK) | ((ptr + AW'(1)) & PMASK);
    assign word_addr    = {ahi, shreg};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            txreg   <= '0;
            ahi     <= '0;
            ptr     <= '0;
            pull    <= 1'b0;
            mack    <= 1'b0;
        end else if (evt.start) begin
            state   <= ST_CTRL;
            bit_cnt <= '0;
            pull    <= 1'b0;
        end else if (evt.stop) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            pull    <= 1'b0;
        end else if (state != ST_IDLE && state != ST_PARK) begin
            if (evt.rise) begin
                bit_cnt <= bit_cnt + 4'd1;
                if (bit_cnt < 4'd8) shreg <= {shreg[6:0], evt.sda};
                if (bit_cnt == 4'd8) mack <= ~evt.sda;
            end
            if (evt.fall) begin
                if (bit_cnt == 4'd8) begin
                    case (state)
                        ST_CTRL: begin
                            if (ctrl_hit(shreg, dev_sel_i)) begin
                                pull  <= 1'b1;
                                mack  <= 1'b1;
                                state <= shreg[0] ? ST_RDATA : ST_AHI;
                            end else begin
                                state <= ST_PARK;
                            end
                        end
                        ST_AHI: begin
                            ahi   <= shreg;
                            pull  <= 1'b1;
                            state <= ST_ALO;
                        end
                        ST_ALO: begin
                            ptr   <= word_addr[AW-1:0];
                            pull  <= 1'b1;
                            state <= ST_WDATA;
                        end
                        ST_WDATA: begin
                            ptr  <= ptr_page_nxt;
                            pull <= 1'b1;
                        end
                        default: pull <= 1'b0;
                    endcase
                end else if (bit_cnt == 4'd9) begin
                    bit_cnt <= '0;
                    if (state == ST_RDATA) begin
                        if (mack) begin
                            txreg <= rdata;
                            pull  <= ~rdata[7];
                            ptr   <= ptr + AW'(1);
                        end else begin
                            pull  <= 1'b0;
                            state <= ST_PARK;
                        end
                    end else begin
                        pull <= 1'b0;
                    end
                end else if (state == ST_RDATA && bit_cnt != 4'd0) begin
                    pull <= ~txreg[3'(7 - bit_cnt)];
                end
            end
        end
    end

    assign sda_pull_o = pull;
    assign busy_o     = (state != ST_IDLE);
    assign ptr_o      = ptr;

    // R8: an idle target never holds the line
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !pull);

    // R8: STOP always lands in idle
    p_stop_idle_r8: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (state == ST_IDLE));

    // R9: START restarts control-byte reception from bit zero
    p_start_restart_r9: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (state == ST_CTRL && bit_cnt == 4'd0 && !pull));

    // R10: the pull enable moves only while SCL is low
    p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(pull) |-> !evt.scl);

    // R4: a stored byte never moves the pointer out of its page
    p_page_hold_r4: assert property (@(posedge clk) disable iff (rst)
        we |=> ((ptr & ~PMASK) == $past(ptr & ~PMASK)));

    // R2: a byte accepted on the eighth falling edge is acknowledged
    p_ack_drive_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> pull);

endmodule

// File: tb/i2c_eeprom_slave_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_tb;
    localparam int DEPTH = 512;
    localparam int AW    = $clog2(DEPTH);
    localparam int HALF  = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          m_scl = 1'b1;
    logic          m_sda = 1'b1;
    logic [2:0]    sel = 3'b101;
    logic          sda_line, pull, busy;
    logic [AW-1:0] ptr;
    int            vectors = 0;
    int            errors  = 0;
    bit            done = 1'b0;

    logic [7:0]    mdl [DEPTH];
    int            mptr = 0;

    always #2 clk = ~clk;

    assign sda_line = m_sda & ~pull;

    i2c_eeprom_slave #(.DEPTH(DEPTH)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .dev_sel_i  (sel),
        .sda_pull_o (pull),
        .busy_o     (busy),
        .ptr_o      (ptr)
    );

    // R10 monitor: any movement of the pull enable while SCL is high
    always @(pull) begin
        if (!rst && m_scl) begin
            vectors++;
            errors++;
            $display("FAIL R10 pull changed to %b while SCL high (expected no change)", pull);
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic got, input logic exp, input string req);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s at %0t: got %b expected %b", req, $time, got, exp);
        end
    endtask

    task automatic chk_v(input int got, input int exp, input string req);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s at %0t: got %0h expected %0h", req, $time, got, exp);
        end
    endtask

    task automatic bit_cycle(input logic b, input logic exp, input string req);
        m_sda = b;
        wait_clk(HALF);
        m_scl = 1'b1;
        wait_clk(HALF);
        @(negedge clk);
        chk(pull, exp, req);
        wait_clk(HALF);
        m_scl = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; wait_clk(HALF);
        m_scl = 1'b1; wait_clk(HALF);
        m_sda = 1'b0; wait_clk(HALF);
        m_scl = 1'b0; wait_clk(HALF);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wait_clk(HALF);
        m_scl = 1'b1; wait_clk(HALF);
        m_sda = 1'b1; wait_clk(HALF);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic ack, input string req);
        for (int i = 7; i >= 0; i--) bit_cycle(v[i], 1'b0, req);
        bit_cycle(1'b1, ack, req);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic ack, input string req);
        for (int i = 7; i >= 0; i--) bit_cycle(1'b1, ~exp[i], req);
        bit_cycle(~ack, 1'b0, req);
    endtask

    function automatic logic [7:0] ctrl(input logic rd);
        return {4'b1010, sel, rd};
    endfunction

    task automatic write_burst(input logic [15:0] a, input int n, input logic [7:0] seed,
                               input string req);
        i2c_start();
        send_byte(ctrl(1'b0), 1'b1, "R1");
        send_byte(a[15:8], 1'b1, "R2");
        send_byte(a[7:0], 1'b1, "R3");
        mptr = int'(a) % DEPTH;
        for (int k = 0; k < n; k++) begin
            logic [7:0] v;
            v = seed + 8'(k * 7);
            send_byte(v, 1'b1, req);
            mdl[mptr] = v;
            mptr = (mptr & ~63) | ((mptr + 1) & 63);
        end
        i2c_stop();
    endtask

    task automatic read_n(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            logic [7:0] e;
            e = mdl[mptr];
            mptr = (mptr + 1) % DEPTH;
            recv_byte(e, (k < n - 1), req);
        end
    endtask

    task automatic rand_read(input logic [15:0] a, input int n, input string req);
        i2c_start();
        send_byte(ctrl(1'b0), 1'b1, "R1");
        send_byte(a[15:8], 1'b1, "R11");
        send_byte(a[7:0], 1'b1, "R3");
        mptr = int'(a) % DEPTH;
        i2c_start();
        @(negedge clk);
        chk(busy, 1'b1, "R9 busy after repeated START");
        send_byte(ctrl(1'b1), 1'b1, "R9");
        read_n(n, req);
        i2c_stop();
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        @(negedge clk);
        chk(pull, 1'b0, "R8 reset pull");
        chk(busy, 1'b0, "R8 reset busy");

        // R3/R4: burst crosses the page end at 0x1FF and wraps to 0x1C0
        write_burst(16'h01F0, 22, 8'h11, "R4");
        @(negedge clk);
        chk_v(int'(ptr), mptr, "R4 pointer after page wrap");
        chk(busy, 1'b0, "R8 busy after STOP");

        // R1: wrong strap value is never acknowledged
        i2c_start();
        send_byte(8'hA2, 1'b0, "R1 strap mismatch");
        send_byte(8'h00, 1'b0, "R1 parked");
        i2c_stop();

        // R9/R6/R7: random read of five bytes, then a clocked byte after NACK
        i2c_start();
        send_byte(ctrl(1'b0), 1'b1, "R1");
        send_byte(8'h01, 1'b1, "R2");
        send_byte(8'hC0, 1'b1, "R3");
        mptr = 16'h01C0;
        i2c_start();
        send_byte(ctrl(1'b1), 1'b1, "R9");
        read_n(5, "R6");
        for (int i = 0; i < 9; i++) bit_cycle(1'b1, 1'b0, "R7 released after NACK");
        i2c_stop();

        // R5: current-address read continues after the last byte read
        i2c_start();
        send_byte(ctrl(1'b1), 1'b1, "R1");
        read_n(1, "R5");
        i2c_stop();

        // R11: high address bits beyond the depth are dropped
        write_burst(16'hFE00, 3, 8'h40, "R11");
        // R6: sequential read wraps from the last location to 0
        rand_read(16'h01FF, 3, "R6");

        // R8: STOP in the middle of a byte, then a byte without START
        i2c_start();
        bit_cycle(1'b1, 1'b0, "R8");
        bit_cycle(1'b0, 1'b0, "R8");
        i2c_stop();
        @(negedge clk);
        chk(busy, 1'b0, "R8 busy after mid-byte STOP");
        send_byte(ctrl(1'b0), 1'b0, "R8 ignored without START");
        @(negedge clk);
        chk(busy, 1'b0, "R8 still idle");

        // R4: 65 data bytes in one page, the last overwrites the first
        write_burst(16'h0040, 65, 8'h03, "R4");
        rand_read(16'h0040, 64, "R4");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog expired (expected completion)");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule